// File: doc/BRIEF.md
# Flash Busy-Status Read Generator

This block sits on the read path of an embedded flash controller. While an internal program or erase algorithm is running, a read of the memory must not return array contents. It must return a status byte that software polls to learn whether the operation has finished or has failed. The block keeps track of the operation kind and the bit-7 value being written. It counts read strobes to drive an alternating bit, records a time-limit fault and reports whether the sector-erase accept window has closed. When the operation ends, it hands the bus back to the array.

The block does not contain the embedded algorithms or the storage array. A sequencer outside the block reports when an operation starts, when it completes and when it has run over its time limit. The block turns these indications into the byte a host sees on each read. After a time-limit fault the status byte stays fixed until a reset command arrives, so software can read the failure at its own pace.

Top module: `poll_status_gen`

## Requirements
- R1: After reset, and whenever no operation is active, `busy` is 0 and `rd_data` equals `array_data` bit for bit. An asynchronous reset abandons any active operation.
- R2: A pulse on `op_start` while idle makes `busy` 1 from the next clock on. On that same edge the block captures `op_is_erase` and `prog_bit7`, and the alternating bit (bit 6) starts at 0.
- R3: During a program (`op_is_erase`=0), status bit 7 reads as the complement of the captured `prog_bit7`. It holds that value for the whole busy period.
- R4: During an erase (`op_is_erase`=1), status bit 7 reads 0.
- R5: While an operation is running and no fault has been flagged, status bit 6 inverts once for each rising edge of `rd_stb`, taken at a clock edge. Holding `rd_stb` high does not invert it again. The bit never changes while idle or faulted.
- R6: Status bits 4, 2, 1 and 0 always read 0 while status is shown.
- R7: Status bit 3 follows `win_closed` during an erase. During a program it reads 0.
- R8: `op_done` while running without a fault returns the block to idle on the next clock, so array data is passed through again.
- R9: `op_timeout` while running enters the fault state on the next clock, and takes priority over an `op_done` in the same cycle. In the fault state, status bit 5 reads 1. The whole status byte then stays frozen: bit 3 keeps the value `win_closed` had at the timeout edge, and `rd_stb`, `win_closed` and `op_done` have no effect.
- R10: `reset_cmd` in the fault state returns the block to idle on the next clock. `reset_cmd` is ignored while running without a fault. `op_start` is ignored in both the running and the fault states.
- R11: Status bit 5 reads 0 while running without a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_start | input | 1 | Embedded operation begins (one-cycle pulse) |
| op_is_erase | input | 1 | Kind of operation starting: 1 erase, 0 program |
| prog_bit7 | input | 1 | Bit 7 of the byte being programmed |
| op_done | input | 1 | Embedded operation finished |
| op_timeout | input | 1 | Embedded operation exceeded its time limit |
| reset_cmd | input | 1 | Reset command decoded; clears a fault |
| win_closed | input | 1 | Sector-erase accept window has closed |
| rd_stb | input | 1 | Read strobe from the host bus |
| array_data | input | DATA_W | Data read from the array |
| rd_data | output | DATA_W | Byte returned to the host |
| busy | output | 1 | Status byte is replacing array data |

## Verification
On every clock the assertions check four things. Reserved status bits stay at zero, and array data passes through while idle. Bit 7 stays steady across a busy period. Each fresh strobe edge inverts bit 6, and a faulted status byte keeps its value until a reset command. The start, done and clear transitions are also checked on every clock. Only the bench scenarios show which value bit 7 takes for each operation kind and target bit, and that bit 3 follows the window flag for erase but not for program. They also show that a timeout and a done arriving together leave the block faulted, and that commands arriving at the wrong time have no visible effect.

// File: rtl/pollst_pkg.sv
package pollst_pkg;

   typedef enum logic [1:0] {
      PS_IDLE  = 2'd0,
      PS_BUSY  = 2'd1,
      PS_FAULT = 2'd2
   } pstate_t;

   // Default placement of the status fields inside the byte.
   localparam int DEF_POLL_POS = 7;
   localparam int DEF_TOG_POS  = 6;
   localparam int DEF_TMO_POS  = 5;
   localparam int DEF_WIN_POS  = 3;

   function automatic bit pos_set_ok(int w, int a, int b, int c, int d);
      return (a < w) && (b < w) && (c < w) && (d < w) &&
             (a != b) && (a != c) && (a != d) &&
             (b != c) && (b != d) && (c != d) &&
             (a >= 0) && (b >= 0) && (c >= 0) && (d >= 0);
   endfunction

endpackage

// File: rtl/pollst_seq.sv
module pollst_seq
   import pollst_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    op_start,
   input  logic    op_is_erase,
   input  logic    prog_bit7,
   input  logic    op_done,
   input  logic    op_timeout,
   input  logic    reset_cmd,
   input  logic    win_closed,
   output pstate_t state_q,
   output logic    erase_q,
   output logic    tgt_q,
   output logic    win_frz_q,
   output logic    start_acc,
   output logic    run_ok
);

   pstate_t state_d;

   assign start_acc = (state_q == PS_IDLE) && op_start;
   assign run_ok    = (state_q == PS_BUSY) && !op_timeout;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         PS_IDLE: begin
            if (op_start) state_d = PS_BUSY;
         end
         PS_BUSY: begin
            if (op_timeout)   state_d = PS_FAULT;
            else if (op_done) state_d = PS_IDLE;
         end
         PS_FAULT: begin
            if (reset_cmd) state_d = PS_IDLE;
         end
         default: state_d = PS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= PS_IDLE;
         erase_q   <= 1'b0;
         tgt_q     <= 1'b0;
         win_frz_q <= 1'b0;
      end else begin
         state_q <= state_d;
         if (start_acc) begin
            erase_q   <= op_is_erase;
            tgt_q     <= prog_bit7;
            win_frz_q <= 1'b0;
         end
         if ((state_q == PS_BUSY) && op_timeout) begin
            win_frz_q <= erase_q & win_closed;
         end
      end
   end

endmodule

// File: rtl/pollst_toggle.sv
module pollst_toggle #(
   parameter bit EDGE_MODE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic en,
   input  logic rd_stb,
   output logic tog_q
);

   logic hit;

   generate
      if (EDGE_MODE) begin : g_edge
         logic rd_prev_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rd_prev_q <= 1'b0;
            else        rd_prev_q <= rd_stb;
         end
         assign hit = rd_stb & ~rd_prev_q;
      end else begin : g_level
         assign hit = rd_stb;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        tog_q <= 1'b0;
      else if (clr)      tog_q <= 1'b0;
      else if (en && hit) tog_q <= ~tog_q;
   end

endmodule

// File: rtl/pollst_fmt.sv
module pollst_fmt
   import pollst_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int POLL_POS = DEF_POLL_POS,
   parameter int TOG_POS  = DEF_TOG_POS,
   parameter int TMO_POS  = DEF_TMO_POS,
   parameter int WIN_POS  = DEF_WIN_POS
) (
   input  pstate_t             state_q,
   input  logic                erase_q,
   input  logic                tgt_q,
   input  logic                tog_q,
   input  logic                win_closed,
   input  logic                win_frz_q,
   input  logic [DATA_W-1:0]   array_data,
   output logic [DATA_W-1:0]   rd_data,
   output logic                busy
);

   logic              show;
   logic              fault;
   logic              poll_bit;
   logic              win_bit;
   logic [DATA_W-1:0] status;

   assign show     = (state_q != PS_IDLE);
   assign fault    = (state_q == PS_FAULT);
   assign poll_bit = ~erase_q & ~tgt_q;
   assign win_bit  = fault ? win_frz_q : (erase_q & win_closed);

   generate
      for (genvar i = 0; i < DATA_W; i++) begin : g_bit
         if (i == POLL_POS) begin : g_poll
            assign status[i] = poll_bit;
         end else if (i == TOG_POS) begin : g_tog
            assign status[i] = tog_q;
         end else if (i == TMO_POS) begin : g_tmo
            assign status[i] = fault;
         end else if (i == WIN_POS) begin : g_win
            assign status[i] = win_bit;
         end else begin : g_zero
            assign status[i] = 1'b0;
         end
      end
   endgenerate

   assign rd_data = show ? status : array_data;
   assign busy    = show;

endmodule

// File: rtl/poll_status_gen.sv
module poll_status_gen
   import pollst_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int POLL_POS  = DEF_POLL_POS,
   parameter int TOG_POS   = DEF_TOG_POS,
   parameter int TMO_POS   = DEF_TMO_POS,
   parameter int WIN_POS   = DEF_WIN_POS,
   parameter bit EDGE_MODE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_start,
   input  logic              op_is_erase,
   input  logic              prog_bit7,
   input  logic              op_done,
   input  logic              op_timeout,
   input  logic              reset_cmd,
   input  logic              win_closed,
   input  logic              rd_stb,
   input  logic [DATA_W-1:0] array_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              busy
);

   localparam bit POS_OK = pos_set_ok(DATA_W, POLL_POS, TOG_POS, TMO_POS, WIN_POS);

   initial begin
      assert (POS_OK) else $error("status field positions overlap or exceed DATA_W");
   end

   pstate_t state_q;
   logic    erase_q;
   logic    tgt_q;
   logic    win_frz_q;
   logic    start_acc;
   logic    run_ok;
   logic    tog_q;

   pollst_seq u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .op_start    (op_start),
      .op_is_erase (op_is_erase),
      .prog_bit7   (prog_bit7),
      .op_done     (op_done),
      .op_timeout  (op_timeout),
      .reset_cmd   (reset_cmd),
      .win_closed  (win_closed),
      .state_q     (state_q),
      .erase_q     (erase_q),
      .tgt_q       (tgt_q),
      .win_frz_q   (win_frz_q),
      .start_acc   (start_acc),
      .run_ok      (run_ok)
   );

   pollst_toggle #(.EDGE_MODE(EDGE_MODE)) u_tog (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (start_acc),
      .en     (run_ok),
      .rd_stb (rd_stb),
      .tog_q  (tog_q)
   );

   pollst_fmt #(
      .DATA_W   (DATA_W),
      .POLL_POS (POLL_POS),
      .TOG_POS  (TOG_POS),
      .TMO_POS  (TMO_POS),
      .WIN_POS  (WIN_POS)
   ) u_fmt (
      .state_q    (state_q),
      .erase_q    (erase_q),
      .tgt_q      (tgt_q),
      .tog_q      (tog_q),
      .win_closed (win_closed),
      .win_frz_q  (win_frz_q),
      .array_data (array_data),
      .rd_data    (rd_data),
      .busy       (busy)
   );

endmodule

// File: rtl/poll_status_gen_chk.sv
module poll_status_gen_chk #(
   parameter int DATA_W   = 8,
   parameter int POLL_POS = 7,
   parameter int TOG_POS  = 6,
   parameter int TMO_POS  = 5,
   parameter int WIN_POS  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              op_start,
   input logic              op_done,
   input logic              op_timeout,
   input logic              reset_cmd,
   input logic              rd_stb,
   input logic [DATA_W-1:0] array_data,
   input logic [DATA_W-1:0] rd_data,
   input logic              busy
);

   localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};
   localparam logic [DATA_W-1:0] STAT_MASK =
      (ONE << POLL_POS) | (ONE << TOG_POS) | (ONE << TMO_POS) | (ONE << WIN_POS);

   assert_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (rd_data == array_data));

   assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && op_start) |=> busy);

   assert_bit7_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> (rd_data[POLL_POS] == $past(rd_data[POLL_POS])));

   assert_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !rd_data[TMO_POS] && $rose(rd_stb) && !op_done && !op_timeout)
      |=> (rd_data[TOG_POS] != $past(rd_data[TOG_POS])));

   assert_quiet_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> ((rd_data & ~STAT_MASK) == '0));

   assert_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !rd_data[TMO_POS] && op_done && !op_timeout) |=> !busy);

   assert_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && rd_data[TMO_POS] && !reset_cmd) |=> (busy && (rd_data == $past(rd_data))));

   assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && rd_data[TMO_POS] && reset_cmd) |=> !busy);

   assert_fresh_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && op_start) |=> !rd_data[TMO_POS]);

endmodule

bind poll_status_gen poll_status_gen_chk #(
   .DATA_W   (DATA_W),
   .POLL_POS (POLL_POS),
   .TOG_POS  (TOG_POS),
   .TMO_POS  (TMO_POS),
   .WIN_POS  (WIN_POS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .op_start   (op_start),
   .op_done    (op_done),
   .op_timeout (op_timeout),
   .reset_cmd  (reset_cmd),
   .rd_stb     (rd_stb),
   .array_data (array_data),
   .rd_data    (rd_data),
   .busy       (busy)
);

// File: tb/poll_status_gen_tb.sv
`timescale 1ns/1ps
module poll_status_gen_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       op_start = 1'b0, op_is_erase = 1'b0, prog_bit7 = 1'b0;
   logic       op_done = 1'b0, op_timeout = 1'b0, reset_cmd = 1'b0;
   logic       win_closed = 1'b0, rd_stb = 1'b0;
   logic [7:0] array_data = 8'h00;
   logic [7:0] rd_data;
   logic       busy;

   int checks = 0;
   int errors = 0;
   bit finished = 0;
   string cur_req = "R1";

   // reference model state: 0 idle, 1 running, 2 faulted
   int m_st = 0;
   bit m_er, m_tgt, m_tog, m_wf, m_prev;

   always #2.5 clk = ~clk;

   poll_status_gen u_dut (
      .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_is_erase(op_is_erase),
      .prog_bit7(prog_bit7), .op_done(op_done), .op_timeout(op_timeout),
      .reset_cmd(reset_cmd), .win_closed(win_closed), .rd_stb(rd_stb),
      .array_data(array_data), .rd_data(rd_data), .busy(busy)
   );

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st = 0; m_er = 0; m_tgt = 0; m_tog = 0; m_wf = 0; m_prev = 0;
      end else begin
         bit rise;
         rise = rd_stb && !m_prev;
         m_prev = rd_stb;
         case (m_st)
            0: if (op_start) begin
                  m_st = 1; m_er = op_is_erase; m_tgt = prog_bit7; m_tog = 0; m_wf = 0;
               end
            1: begin
                  if (rise && !op_timeout) m_tog = !m_tog;
                  if (op_timeout) begin m_st = 2; m_wf = m_er && win_closed; end
                  else if (op_done) m_st = 0;
               end
            default: if (reset_cmd) m_st = 0;
         endcase
      end
   end

   function automatic logic [7:0] model_out();
      logic [7:0] s;
      if (m_st == 0) return array_data;
      s = 8'h00;
      s[7] = !m_er && !m_tgt;
      s[6] = m_tog;
      s[5] = (m_st == 2);
      s[3] = (m_st == 2) ? m_wf : (m_er && win_closed);
      return s;
   endfunction

   task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
      end
   endtask

   // per-cycle comparison with the model, away from the clock edge
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         check(cur_req, "cycle rd_data", rd_data, model_out());
         check(cur_req, "cycle busy", {7'd0, busy}, {7'd0, m_st != 0});
      end
   end

   task automatic tick(int n = 1);
      repeat (n) begin @(posedge clk); #1; end
   endtask

   task automatic expect_at(string req, logic [7:0] exp_data, bit exp_busy);
      @(negedge clk);
      check(req, "rd_data", rd_data, exp_data);
      check(req, "busy", {7'd0, busy}, {7'd0, exp_busy});
   endtask

   task automatic pulse_start(bit er, bit b7);
      op_is_erase = er; prog_bit7 = b7; op_start = 1; tick(); op_start = 0;
   endtask

   task automatic pulse_stb();
      rd_stb = 1; tick(); rd_stb = 0; tick();
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      array_data = 8'h5A;
      tick(3);
      rst_n = 1;
      tick();
      cur_req = "R1";
      expect_at("R1", 8'h5A, 0);
      array_data = 8'hC3; tick();
      expect_at("R1", 8'hC3, 0);

      // program, target bit7 = 1
      cur_req = "R2";
      pulse_start(0, 1);
      expect_at("R2", 8'h00, 1);
      expect_at("R3", 8'h00, 1);
      cur_req = "R5";
      rd_stb = 1; tick();
      expect_at("R5", 8'h40, 1);
      tick(2);
      expect_at("R5", 8'h40, 1);            // held high: no further flip
      rd_stb = 0; tick(); rd_stb = 1; tick();
      expect_at("R5", 8'h00, 1);
      rd_stb = 0; tick();
      cur_req = "R8";
      op_done = 1; tick(); op_done = 0;
      expect_at("R8", 8'hC3, 0);
      pulse_stb();
      expect_at("R5", 8'hC3, 0);            // idle: strobes change nothing visible

      // program, target bit7 = 0
      cur_req = "R3";
      pulse_start(0, 0);
      expect_at("R3", 8'h80, 1);
      cur_req = "R10";
      op_is_erase = 1; prog_bit7 = 1; op_start = 1; tick(); op_start = 0;
      expect_at("R10", 8'h80, 1);           // start ignored while running
      reset_cmd = 1; tick(); reset_cmd = 0;
      expect_at("R10", 8'h80, 1);           // reset command ignored while running
      cur_req = "R7";
      win_closed = 1; tick();
      expect_at("R7", 8'h80, 1);            // program: bit3 stays 0
      expect_at("R11", 8'h80, 1);
      win_closed = 0;
      op_done = 1; tick(); op_done = 0;
      expect_at("R8", 8'hC3, 0);

      // erase with window flag and timeout
      cur_req = "R4";
      pulse_start(1, 1);
      expect_at("R4", 8'h00, 1);
      cur_req = "R7";
      win_closed = 1;
      expect_at("R7", 8'h08, 1);
      pulse_stb();
      expect_at("R6", 8'h48, 1);
      cur_req = "R9";
      op_timeout = 1; tick(); op_timeout = 0;
      expect_at("R9", 8'h68, 1);
      win_closed = 0;
      pulse_stb();
      op_done = 1; tick(); op_done = 0;
      expect_at("R9", 8'h68, 1);
      cur_req = "R10";
      op_start = 1; tick(); op_start = 0;
      expect_at("R10", 8'h68, 1);
      reset_cmd = 1; tick(); reset_cmd = 0;
      expect_at("R10", 8'hC3, 0);

      // timeout and done in the same cycle
      cur_req = "R9";
      pulse_start(0, 1);
      op_done = 1; op_timeout = 1; tick(); op_done = 0; op_timeout = 0;
      expect_at("R9", 8'h20, 1);
      reset_cmd = 1; tick(); reset_cmd = 0;
      expect_at("R10", 8'hC3, 0);

      // asynchronous reset abandons an operation
      cur_req = "R1";
      pulse_start(1, 0);
      expect_at("R4", 8'h00, 1);
      rst_n = 0; tick(); rst_n = 1; tick();
      expect_at("R1", 8'hC3, 0);

      // random stress against the model
      cur_req = "R5";
      for (int i = 0; i < 2000; i++) begin
         op_start    = ($urandom_range(0, 7) == 0);
         op_is_erase = $urandom_range(0, 1);
         prog_bit7   = $urandom_range(0, 1);
         op_done     = ($urandom_range(0, 15) == 0);
         op_timeout  = ($urandom_range(0, 40) == 0);
         reset_cmd   = ($urandom_range(0, 9) == 0);
         win_closed  = $urandom_range(0, 1);
         rd_stb      = $urandom_range(0, 1);
         array_data  = 8'($urandom);
         tick();
      end
      finish_run();
   end

endmodule